// File: doc/BRIEF.md
# Scoreboard Hazard Controller

This block sequences floating-point operations through four phases: issue, operand read, execute and result write. It serves a pool of functional units: a group of multiply units and a group of add/subtract units. Two tables drive its decisions. The unit-status table records, for each unit, the destination, both source registers, the unit expected to produce each source and a flag that says whether that source is available. The result-status table maps each architectural register to the unit that will write it. Each cycle the controller uses both tables to decide which operations move forward.

Instructions arrive in program order on a valid/ready stream and are issued in that order. After issue they can finish out of order. A missing source holds an operation at operand read. A register that an older operation has not yet read holds the writer at result write. Because the two waits sit in different phases, a reader waiting for a producer never holds that producer back. The execution units report completion with one pulse per unit. The controller reports every phase grant per unit and a free-running cycle number, and together these form a per-cycle trace.

Top module: `sb_ctrl`

## Requirements
- R1: Every operation goes through issue, operand read, execute and result write in that order. Issue, operand read and result write each take one cycle, and operand read is no earlier than the cycle after issue.
- R2: `exe_start[u]` pulses in the cycle after the operand-read grant of unit u. The result-write grant comes no earlier than the cycle after `exe_done[u]`. With a 3-cycle multiply and a 1-cycle add, an operation that meets no waits issues in cycle 1, reads in 2 and writes in 6 (multiply) or 4 (add/subtract).
- R3: Units 0 to NUM_MUL-1 are multiply units and take `in_op` 2 or 3. The remaining units are add/subtract units and take `in_op` 0 (add) or 1 (subtract). Issue picks the lowest-numbered free unit of the right class and reports it on `iss_unit`. `in_ready` stays low while no unit of the class is free.
- R4: `in_ready` stays low while any active operation has `in_dst` as its destination (WAW).
- R5: A source that a still-active earlier operation will write holds its reader at operand read. Operand read is granted in the cycle after the producer's result write.
- R6: A result write is held while another unit in operand read still has that destination as an unread available source. The write proceeds in the cycle after that read.
- R7: A reader waiting on a source never delays the producer's result write, so the operations finish without deadlock and may finish out of program order.
- R8: A unit's entry is cleared at the end of its result-write cycle, and the unit can issue again in the next cycle.
- R9: After reset no unit is busy, no grant or start is active, `in_ready` is high and `cycle_num` is 0.
- R10: `cycle_num` goes up by one on every clock edge outside reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | An instruction is presented |
| in_op | input | 2 | 0 add, 1 subtract, 2/3 multiply |
| in_dst | input | REG_W | Destination register |
| in_src1 | input | REG_W | First source register |
| in_src2 | input | REG_W | Second source register |
| exe_done | input | NFU | Last-execute-cycle pulse, one bit per unit |
| in_ready | output | 1 | Presented instruction issues this cycle if valid |
| iss_unit | output | FU_W | Unit that receives the issuing instruction |
| rd_grant | output | NFU | Operand read happens this cycle, per unit |
| exe_start | output | NFU | First execute cycle, per unit |
| wr_grant | output | NFU | Result write happens this cycle, per unit |
| cycle_num | output | CYC_W | Cycles since reset |

## Verification
Bad table state shows up as wrong grant cycles. A source-ready flag that is set wrongly makes a read grant come early or never. A stale result-status entry blocks `in_ready` for good. A missing clear keeps a unit from being issued again. Each of these appears within a few cycles of the write that should have fixed it. The bench replays a classic RAW/WAR mix, structural pressure on the multiply units and a WAW pair. It compares every grant against a trace computed by hand, cycle by cycle, so any misplaced event is reported in the cycle it occurs.

// File: rtl/sb_pkg.sv
package sb_pkg;

    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,
        PH_READ  = 2'd1,
        PH_EXEC  = 2'd2,
        PH_WRITE = 2'd3
    } phase_e;

    localparam logic [1:0] OPC_ADD = 2'd0;
    localparam logic [1:0] OPC_SUB = 2'd1;
    localparam logic [1:0] OPC_MUL = 2'd2;

    function automatic logic needs_mul(input logic [1:0] op);
        return op >= OPC_MUL;
    endfunction

endpackage

// File: rtl/sb_issue_sel.sv
module sb_issue_sel #(
    parameter int NUM_MUL = 2,
    parameter int NUM_ADD = 2,
    localparam int NFU  = NUM_MUL + NUM_ADD,
    localparam int FU_W = $clog2(NFU)
) (
    input  logic [NFU-1:0]  busy,
    input  logic            want_mul,
    output logic            found,
    output logic [FU_W-1:0] idx
);
    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int i = NFU - 1; i >= 0; i--) begin
            if (!busy[i] && ((i < NUM_MUL) == want_mul)) begin
                found = 1'b1;
                idx   = FU_W'(i);
            end
        end
    end
endmodule

// File: rtl/sb_regstat.sv
module sb_regstat #(
    parameter int NFU      = 4,
    parameter int NUM_REGS = 32,
    localparam int FU_W  = $clog2(NFU),
    localparam int REG_W = $clog2(NUM_REGS)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             set_en,
    input  logic [REG_W-1:0] set_reg,
    input  logic [FU_W-1:0]  set_idx,
    input  logic [NFU-1:0]   clr_en,
    input  logic [REG_W-1:0] clr_reg [NFU],
    input  logic [REG_W-1:0] look_reg [3],
    output logic             look_vld [3],
    output logic [FU_W-1:0]  look_idx [3]
);
    logic [NUM_REGS-1:0] vld_q;
    logic [FU_W-1:0]     idx_q [NUM_REGS];

    always_ff @(posedge clk) begin
        if (rst) begin
            vld_q <= '0;
            for (int r = 0; r < NUM_REGS; r++) idx_q[r] <= '0;
        end else begin
            for (int f = 0; f < NFU; f++) begin
                if (clr_en[f]) vld_q[clr_reg[f]] <= 1'b0;
            end
            if (set_en) begin
                vld_q[set_reg] <= 1'b1;
                idx_q[set_reg] <= set_idx;
            end
        end
    end

    always_comb begin
        for (int k = 0; k < 3; k++) begin
            look_vld[k] = vld_q[look_reg[k]];
            look_idx[k] = idx_q[look_reg[k]];
        end
    end
endmodule

// File: rtl/sb_fu_slot.sv
module sb_fu_slot
    import sb_pkg::*;
#(
    parameter int NFU   = 4,
    parameter int REG_W = 5,
    localparam int FU_W = $clog2(NFU)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             issue,
    input  logic [REG_W-1:0] dst_in,
    input  logic [REG_W-1:0] src1_in,
    input  logic [REG_W-1:0] src2_in,
    input  logic             q1_pend,
    input  logic [FU_W-1:0]  q1_in,
    input  logic             q2_pend,
    input  logic [FU_W-1:0]  q2_in,
    input  logic [NFU-1:0]   wr_bus,
    input  logic             exe_done,
    input  logic             war_hold,
    output logic             busy,
    output phase_e           phase,
    output logic [REG_W-1:0] dst,
    output logic [REG_W-1:0] src1,
    output logic [REG_W-1:0] src2,
    output logic             r1,
    output logic             r2,
    output logic             rd_go,
    output logic             wr_go,
    output logic             ex_start
);
    phase_e           phase_q;
    logic [REG_W-1:0] dst_q, s1_q, s2_q;
    logic [FU_W-1:0]  q1_q, q2_q;
    logic             r1_q, r2_q, start_q;

    assign busy     = phase_q != PH_IDLE;
    assign phase    = phase_q;
    assign dst      = dst_q;
    assign src1     = s1_q;
    assign src2     = s2_q;
    assign r1       = r1_q;
    assign r2       = r2_q;
    assign ex_start = start_q;
    assign rd_go    = (phase_q == PH_READ) && r1_q && r2_q;
    assign wr_go    = (phase_q == PH_WRITE) && !war_hold;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= PH_IDLE;
            dst_q   <= '0;
            s1_q    <= '0;
            s2_q    <= '0;
            q1_q    <= '0;
            q2_q    <= '0;
            r1_q    <= 1'b0;
            r2_q    <= 1'b0;
            start_q <= 1'b0;
        end else begin
            start_q <= rd_go;
            unique case (phase_q)
                PH_IDLE: begin
                    if (issue) begin
                        phase_q <= PH_READ;
                        dst_q   <= dst_in;
                        s1_q    <= src1_in;
                        s2_q    <= src2_in;
                        q1_q    <= q1_in;
                        q2_q    <= q2_in;
                        r1_q    <= !q1_pend;
                        r2_q    <= !q2_pend;
                    end
                end
                PH_READ: begin
                    if (rd_go) begin
                        phase_q <= PH_EXEC;
                        r1_q    <= 1'b0;
                        r2_q    <= 1'b0;
                    end else begin
                        if (!r1_q && wr_bus[q1_q]) r1_q <= 1'b1;
                        if (!r2_q && wr_bus[q2_q]) r2_q <= 1'b1;
                    end
                end
                PH_EXEC: begin
                    if (exe_done) phase_q <= PH_WRITE;
                end
                PH_WRITE: begin
                    if (wr_go) begin
                        phase_q <= PH_IDLE;
                        dst_q   <= '0;
                        s1_q    <= '0;
                        s2_q    <= '0;
                        q1_q    <= '0;
                        q2_q    <= '0;
                    end
                end
                default: phase_q <= PH_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/sb_ctrl.sv
module sb_ctrl
    import sb_pkg::*;
#(
    parameter int NUM_MUL  = 2,
    parameter int NUM_ADD  = 2,
    parameter int NUM_REGS = 32,
    parameter int CYC_W    = 32,
    localparam int NFU   = NUM_MUL + NUM_ADD,
    localparam int FU_W  = $clog2(NFU),
    localparam int REG_W = $clog2(NUM_REGS)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             in_valid,
    input  logic [1:0]       in_op,
    input  logic [REG_W-1:0] in_dst,
    input  logic [REG_W-1:0] in_src1,
    input  logic [REG_W-1:0] in_src2,
    input  logic [NFU-1:0]   exe_done,
    output logic             in_ready,
    output logic [FU_W-1:0]  iss_unit,
    output logic [NFU-1:0]   rd_grant,
    output logic [NFU-1:0]   exe_start,
    output logic [NFU-1:0]   wr_grant,
    output logic [CYC_W-1:0] cycle_num
);
    logic [NFU-1:0]   busy, r1, r2, war_hold;
    phase_e           phase [NFU];
    logic [REG_W-1:0] f_dst [NFU];
    logic [REG_W-1:0] f_s1  [NFU];
    logic [REG_W-1:0] f_s2  [NFU];

    logic             sel_found, issue;
    logic [FU_W-1:0]  sel_idx;
    logic [REG_W-1:0] look_reg [3];
    logic             look_vld [3];
    logic [FU_W-1:0]  look_idx [3];
    logic             q1_pend, q2_pend;

    sb_issue_sel #(.NUM_MUL(NUM_MUL), .NUM_ADD(NUM_ADD)) u_sel (
        .busy     (busy),
        .want_mul (needs_mul(in_op)),
        .found    (sel_found),
        .idx      (sel_idx)
    );

    assign look_reg[0] = in_src1;
    assign look_reg[1] = in_src2;
    assign look_reg[2] = in_dst;

    sb_regstat #(.NFU(NFU), .NUM_REGS(NUM_REGS)) u_rstat (
        .clk      (clk),
        .rst      (rst),
        .set_en   (issue),
        .set_reg  (in_dst),
        .set_idx  (sel_idx),
        .clr_en   (wr_grant),
        .clr_reg  (f_dst),
        .look_reg (look_reg),
        .look_vld (look_vld),
        .look_idx (look_idx)
    );

    assign in_ready = sel_found && !look_vld[2];
    assign iss_unit = sel_idx;
    assign issue    = in_valid && in_ready;
    // a producer writing in the issue cycle already counts as delivered
    assign q1_pend  = look_vld[0] && !wr_grant[look_idx[0]];
    assign q2_pend  = look_vld[1] && !wr_grant[look_idx[1]];

    for (genvar g = 0; g < NFU; g++) begin : g_slot
        sb_fu_slot #(.NFU(NFU), .REG_W(REG_W)) u_slot (
            .clk      (clk),
            .rst      (rst),
            .issue    (issue && (sel_idx == FU_W'(g))),
            .dst_in   (in_dst),
            .src1_in  (in_src1),
            .src2_in  (in_src2),
            .q1_pend  (q1_pend),
            .q1_in    (look_idx[0]),
            .q2_pend  (q2_pend),
            .q2_in    (look_idx[1]),
            .wr_bus   (wr_grant),
            .exe_done (exe_done[g]),
            .war_hold (war_hold[g]),
            .busy     (busy[g]),
            .phase    (phase[g]),
            .dst      (f_dst[g]),
            .src1     (f_s1[g]),
            .src2     (f_s2[g]),
            .r1       (r1[g]),
            .r2       (r2[g]),
            .rd_go    (rd_grant[g]),
            .wr_go    (wr_grant[g]),
            .ex_start (exe_start[g])
        );
    end

    // WAR: hold writer f while another unit still owes a read of f's target
    always_comb begin
        for (int f = 0; f < NFU; f++) begin
            war_hold[f] = 1'b0;
            for (int g = 0; g < NFU; g++) begin
                if (g != f && phase[g] == PH_READ &&
                    ((r1[g] && f_s1[g] == f_dst[f]) ||
                     (r2[g] && f_s2[g] == f_dst[f])))
                    war_hold[f] = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) cycle_num <= '0;
        else     cycle_num <= cycle_num + 1'b1;
    end
endmodule

// File: rtl/sb_ctrl_chk.sv
module sb_ctrl_chk #(
    parameter int NUM_MUL  = 2,
    parameter int NUM_ADD  = 2,
    parameter int NUM_REGS = 32,
    localparam int NFU   = NUM_MUL + NUM_ADD,
    localparam int REG_W = $clog2(NUM_REGS)
) (
    input logic             clk,
    input logic             rst,
    input logic             in_valid,
    input logic [REG_W-1:0] in_dst,
    input logic             in_ready,
    input logic [NFU-1:0]   rd_grant,
    input logic [NFU-1:0]   exe_start,
    input logic [NFU-1:0]   wr_grant
);
    for (genvar u = 0; u < NFU; u++) begin : g_unit
        p_start_after_read_r2: assert property (@(posedge clk) disable iff (rst)
            rd_grant[u] |=> exe_start[u]);
        p_start_needs_read_r2: assert property (@(posedge clk) disable iff (rst)
            exe_start[u] |-> $past(rd_grant[u]));
        p_one_phase_r1: assert property (@(posedge clk) disable iff (rst)
            $onehot0({rd_grant[u], exe_start[u], wr_grant[u]}));
        p_idle_after_write_r8: assert property (@(posedge clk) disable iff (rst)
            wr_grant[u] |=> !rd_grant[u] && !wr_grant[u] && !exe_start[u]);
    end

    p_no_twin_dst_r4: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_ready) |=> !(in_valid && in_ready && in_dst == $past(in_dst)));
endmodule

bind sb_ctrl sb_ctrl_chk #(.NUM_MUL(NUM_MUL), .NUM_ADD(NUM_ADD), .NUM_REGS(NUM_REGS)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .in_dst    (in_dst),
    .in_ready  (in_ready),
    .rd_grant  (rd_grant),
    .exe_start (exe_start),
    .wr_grant  (wr_grant)
);

// File: tb/sb_ctrl_test.sv
module sb_ctrl_test;
    localparam int NUM_MUL = 2, NUM_ADD = 2, NUM_REGS = 32, CYC_W = 32;
    localparam int NFU = NUM_MUL + NUM_ADD;
    localparam int FU_W = $clog2(NFU), REG_W = $clog2(NUM_REGS);

    logic clk = 0, rst = 1, in_valid = 0;
    logic [1:0] in_op = 0;
    logic [REG_W-1:0] in_dst = 0, in_src1 = 0, in_src2 = 0;
    logic [NFU-1:0] exe_done = 0;
    logic in_ready;
    logic [FU_W-1:0] iss_unit;
    logic [NFU-1:0] rd_grant, exe_start, wr_grant;
    logic [CYC_W-1:0] cycle_num;

    always #10 clk = ~clk;

    sb_ctrl #(.NUM_MUL(NUM_MUL), .NUM_ADD(NUM_ADD), .NUM_REGS(NUM_REGS), .CYC_W(CYC_W)) uut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_op(in_op), .in_dst(in_dst),
        .in_src1(in_src1), .in_src2(in_src2), .exe_done(exe_done), .in_ready(in_ready),
        .iss_unit(iss_unit), .rd_grant(rd_grant), .exe_start(exe_start),
        .wr_grant(wr_grant), .cycle_num(cycle_num));

    int checks = 0, errors = 0, base = 0;
    bit mon_on = 0, finished = 0;

    typedef struct { int t; int kind; int unit; string req; } ev_t;
    ev_t exp_q[$];
    string kname [4] = '{"issue", "read", "start", "write"};

    task automatic expect_ev(input int t, input int k, input int u, input string r);
        ev_t e;
        e.t = t; e.kind = k; e.unit = u; e.req = r;
        exp_q.push_back(e);
    endtask

    task automatic check(input bit ok, input string r, input string what, input int act, input int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", r, what, act, expv);
        end
    endtask

    task automatic observe(input int t, input int k, input int u);
        ev_t e;
        checks++;
        if (exp_q.size() == 0) begin
            errors++;
            $display("FAIL R1 unexpected %s unit %0d at t%0d: actual event expected none", kname[k], u, t);
        end else begin
            e = exp_q.pop_front();
            if (e.t != t || e.kind != k || e.unit != u) begin
                errors++;
                $display("FAIL %s actual %s u%0d t%0d expected %s u%0d t%0d",
                         e.req, kname[k], u, t, kname[e.kind], e.unit, e.t);
            end
        end
    endtask

    // execution units: multiply 3 cycles, add/subtract 1 cycle
    int cnt [NFU];
    always @(negedge clk) begin
        for (int f = 0; f < NFU; f++) begin
            if (rst) begin
                cnt[f] = 0;
                exe_done[f] = 1'b0;
            end else begin
                if (exe_start[f]) cnt[f] = (f < NUM_MUL) ? 3 : 1;
                exe_done[f] = (cnt[f] == 1);
                if (cnt[f] > 0) cnt[f]--;
            end
        end
    end

    // monitor: compares observed grants against the expected trace
    always @(negedge clk) begin
        #2;
        if (mon_on) begin
            int t;
            t = int'(cycle_num) - base + 1;
            if (in_valid && in_ready) observe(t, 0, int'(iss_unit));
            for (int f = 0; f < NFU; f++) if (rd_grant[f])  observe(t, 1, f);
            for (int f = 0; f < NFU; f++) if (exe_start[f]) observe(t, 2, f);
            for (int f = 0; f < NFU; f++) if (wr_grant[f])  observe(t, 3, f);
        end
    end

    // called at a negedge; returns at the next negedge after issue
    task automatic issue(input logic [1:0] op, input int d, input int a, input int b, output int stalls);
        stalls = 0;
        in_valid = 1; in_op = op;
        in_dst = REG_W'(d); in_src1 = REG_W'(a); in_src2 = REG_W'(b);
        #1;
        while (!in_ready) begin
            stalls++;
            @(negedge clk); #1;
        end
        @(negedge clk);
    endtask

    task automatic drain(input string r);
        in_valid = 0;
        repeat (14) @(negedge clk);
        check(exp_q.size() == 0, r, "pending expected events", exp_q.size(), 0);
        exp_q.delete();
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    initial begin
        repeat (2000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
    end

    initial begin
        int st;
        int c0;
        repeat (3) @(negedge clk);
        #1;
        // R9: reset state
        check(in_ready == 1'b1, "R9", "in_ready in reset", in_ready, 1);
        check(rd_grant == 0 && exe_start == 0 && wr_grant == 0, "R9", "grants in reset",
              int'(rd_grant | exe_start | wr_grant), 0);
        check(cycle_num == 0, "R9", "cycle_num in reset", int'(cycle_num), 0);
        rst = 0;
        @(negedge clk);
        // R10: cycle counter
        c0 = int'(cycle_num);
        check(c0 == 1, "R10", "cycle_num first cycle", c0, 1);
        repeat (5) @(negedge clk);
        check(int'(cycle_num) == c0 + 5, "R10", "cycle_num after 5", int'(cycle_num), c0 + 5);
        mon_on = 1;

        // Scenario 1: MUL F0,F6,F4 ; SUB F8,F0,F2 ; ADD F2,F10,F2
        expect_ev(1, 0, 0, "R3");
        expect_ev(2, 0, 2, "R3"); expect_ev(2, 1, 0, "R1");
        expect_ev(3, 0, 3, "R3"); expect_ev(3, 2, 0, "R2");
        expect_ev(4, 1, 3, "R1");
        expect_ev(5, 2, 3, "R2");
        expect_ev(6, 3, 0, "R7");
        expect_ev(7, 1, 2, "R5");
        expect_ev(8, 2, 2, "R2"); expect_ev(8, 3, 3, "R6");
        expect_ev(9, 3, 2, "R7");
        base = int'(cycle_num);
        issue(2'd2, 0, 6, 4, st);  check(st == 0, "R1", "stalls mul", st, 0);
        issue(2'd1, 8, 0, 2, st);  check(st == 0, "R7", "stalls sub", st, 0);
        issue(2'd0, 2, 10, 2, st); check(st == 0, "R6", "stalls add", st, 0);
        drain("R7");

        // Scenario 2: three independent multiplies on two units
        expect_ev(1, 0, 0, "R3");
        expect_ev(2, 0, 1, "R3"); expect_ev(2, 1, 0, "R1");
        expect_ev(3, 1, 1, "R1"); expect_ev(3, 2, 0, "R2");
        expect_ev(4, 2, 1, "R2");
        expect_ev(6, 3, 0, "R2");
        expect_ev(7, 0, 0, "R8"); expect_ev(7, 3, 1, "R2");
        expect_ev(8, 1, 0, "R8");
        expect_ev(9, 2, 0, "R2");
        expect_ev(12, 3, 0, "R2");
        base = int'(cycle_num);
        issue(2'd2, 1, 2, 3, st);
        issue(2'd3, 4, 5, 6, st);
        issue(2'd2, 7, 8, 9, st);  check(st == 4, "R3", "structural stall cycles", st, 4);
        drain("R8");

        // Scenario 3: WAW pair on F1 with a free add unit available
        expect_ev(1, 0, 2, "R3");
        expect_ev(2, 1, 2, "R1");
        expect_ev(3, 2, 2, "R2");
        expect_ev(4, 3, 2, "R2");
        expect_ev(5, 0, 2, "R4");
        expect_ev(6, 1, 2, "R1");
        expect_ev(7, 2, 2, "R2");
        expect_ev(8, 3, 2, "R4");
        base = int'(cycle_num);
        issue(2'd0, 1, 2, 3, st);
        issue(2'd1, 1, 4, 5, st);  check(st == 3, "R4", "WAW stall cycles", st, 3);
        drain("R4");

        summary();
    end
endmodule